// File: doc/BRIEF.md
# Timestamp Port Alignment Offset Unit

This block lines up a slave audio port with a master port by comparing hardware timestamps. A free-running 64-bit tick counter (19.2 MHz) is sampled when the master's double buffer swaps and again when the slave's double buffer swaps. At each slave swap the unit turns the stamp difference into a signed integer sample offset. The slave adds this offset when it indexes its buffer. A user safety margin in microseconds is added before the result is rounded down to whole samples.

The divisions run in one sequential restoring divider that is shared by two jobs. The first job produces the sample offset and the second produces the skew in microseconds. When both are finished, a one-cycle pulse marks the new status. Besides the status words, the unit counts block cycles and holds the audio path at zero for a programmed number of blocks after start. It also raises an error code if no master swap is seen within a timeout.

Top module: `tsa_align_top`

## Requirements
- R1: After reset, every status output, the block counter, the error code, the update pulse and the audio output are zero.
- R2: `stat_started` follows `start` one clock later. While it is low, the captured stamps, the block counter, the settling count, the status words and the error code are all held at zero.
- R3: A slave swap pulse accepted while started captures `ts_now` at that clock edge, and `stat_ts_lo` then shows its low 32 bits. A master swap pulse likewise captures the master stamp that the next computation uses.
- R4: Let D = master stamp − slave stamp. Each update sets `stat_rw_off` (signed 16-bit) to floor((5·D + 96·delay_us) / (5·sample_ticks)), which equals floor((D + 19.2·delay_us) / sample_ticks). Negative numerators round toward minus infinity, and exactly one `upd_done` pulse marks each update.
- R5: At the same update, `stat_skew_us` (signed 32-bit) becomes floor(5·D / 96), which is the skew in whole microseconds.
- R6: At the same update, `stat_latency` becomes the same value as the offset.
- R7: `pump_cnt` increases by exactly one for each slave swap while started. Swap pulses arriving while not started change nothing.
- R8: `audio_out` is zero while not started, and also until `settle_blocks` slave swaps have been counted since start. After that it equals `audio_in`.
- R9: If no master swap has been seen within TIMEOUT_CYC clocks of start, `err_code` becomes 1 and stays at 1 until `start` falls. The value 0 means no error.
- R10: A slave swap that occurs before any master swap has been captured produces no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Port enable |
| ts_now | input | 64 | Free-running tick counter |
| mst_flip | input | 1 | Master buffer swap pulse |
| slv_flip | input | 1 | Slave buffer swap pulse |
| safe_delay_us | input | 16 | Safety margin in microseconds |
| sample_ticks | input | 16 | Sample period in ticks, nonzero |
| settle_blocks | input | 8 | Blocks of forced silence after start |
| audio_in | input | AUD_W | Slave audio sample in |
| audio_out | output | AUD_W | Audio out, zero while muted |
| upd_done | output | 1 | Pulse when a new offset is posted |
| stat_started | output | 1 | Started flag |
| stat_ts_lo | output | 32 | Low word of last slave stamp |
| stat_skew_us | output | 32 | Signed skew in microseconds |
| stat_rw_off | output | 16 | Signed buffer index offset |
| stat_latency | output | 16 | Signed latency in samples |
| pump_cnt | output | 32 | Block cycle count |
| err_code | output | 2 | 0 none, 1 no master swap seen |

## Verification
A wrong master or slave stamp, or a divider that rounds in the wrong direction, shows up as an incorrect `stat_rw_off` or `stat_skew_us` at the next `upd_done` pulse, about 85 clocks after the slave swap. Negative differences and exact multiples of the period are the cases that expose a floor error. A miscounted settling counter unmutes `audio_out` one block too early or too late, and this is visible on the clock after the relevant swap. A stuck timeout counter either never raises `err_code` or raises it while stamps are still flowing.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int TS_W   = 64;
    localparam int DIFF_W = 32;
    localparam int NUM_W  = 40;
    localparam int DEN_W  = 24;
    localparam int PAR_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SKEW_W = 32;

    typedef enum logic [1:0] {ST_IDLE, ST_OFFSET, ST_SKEW} ctl_state_t;
    typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_NO_MASTER = 2'd1} err_t;

    typedef struct packed {
        logic signed [SKEW_W-1:0] skew_us;
        logic signed [OFF_W-1:0]  rw_off;
        logic signed [OFF_W-1:0]  latency;
    } status_t;

    localparam logic signed [NUM_W-1:0] OFF_MAX  = NUM_W'(32767);
    localparam logic signed [NUM_W-1:0] OFF_MIN  = -NUM_W'(32768);
    localparam logic signed [NUM_W-1:0] SKEW_MAX = NUM_W'(64'sh7FFF_FFFF);
    localparam logic signed [NUM_W-1:0] SKEW_MIN = -NUM_W'(64'sh8000_0000);
    localparam logic signed [TS_W-1:0]  DIFF_MAX = TS_W'(64'sh7FFF_FFFF);
    localparam logic signed [TS_W-1:0]  DIFF_MIN = -TS_W'(64'sh8000_0000);

    function automatic logic signed [NUM_W-1:0] mul5(input logic signed [NUM_W-1:0] v);
        return (v <<< 2) + v;
    endfunction

    function automatic logic signed [NUM_W-1:0] us_to_x5ticks(input logic [PAR_W-1:0] us);
        logic signed [NUM_W-1:0] d;
        d = NUM_W'(us);
        return (d <<< 6) + (d <<< 5);
    endfunction

    function automatic logic signed [DIFF_W-1:0] clamp_diff(input logic signed [TS_W-1:0] v);
        if (v > DIFF_MAX) return DIFF_W'(DIFF_MAX);
        if (v < DIFF_MIN) return DIFF_W'(DIFF_MIN);
        return DIFF_W'(v);
    endfunction

    function automatic logic signed [OFF_W-1:0] clamp_off(input logic signed [NUM_W-1:0] v);
        if (v > OFF_MAX) return OFF_W'(OFF_MAX);
        if (v < OFF_MIN) return OFF_W'(OFF_MIN);
        return OFF_W'(v);
    endfunction

    function automatic logic signed [SKEW_W-1:0] clamp_skew(input logic signed [NUM_W-1:0] v);
        if (v > SKEW_MAX) return SKEW_W'(SKEW_MAX);
        if (v < SKEW_MIN) return SKEW_W'(SKEW_MIN);
        return SKEW_W'(v);
    endfunction
endpackage

// File: rtl/tsa_floor_div.sv
module tsa_floor_div #(
    parameter int NW = 40,
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic signed [NW-1:0] num,
    input  logic [DW-1:0]        den,
    output logic                 busy,
    output logic                 done,
    output logic signed [NW-1:0] quot
);
    localparam int CNT_W = $clog2(NW + 1);

    logic [NW-1:0]    q_r;
    logic [DW-1:0]    rem_r;
    logic [DW-1:0]    den_r;
    logic             neg_r;
    logic [CNT_W-1:0] cnt_r;

    logic [DW:0]   rem_sh;
    logic [DW:0]   sub;
    logic          fits;
    logic [DW-1:0] rem_nx;
    logic [NW-1:0] q_nx;

    always_comb begin
        rem_sh = {rem_r, q_r[NW-1]};
        sub    = rem_sh - {1'b0, den_r};
        fits   = !sub[DW];
        rem_nx = fits ? sub[DW-1:0] : rem_sh[DW-1:0];
        q_nx   = {q_r[NW-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            rem_r <= '0;
            den_r <= '0;
            neg_r <= 1'b0;
            cnt_r <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            quot  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q_r   <= num[NW-1] ? NW'(-num) : NW'(num);
                neg_r <= num[NW-1];
                rem_r <= '0;
                den_r <= den;
                cnt_r <= CNT_W'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                q_r   <= q_nx;
                rem_r <= rem_nx;
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!neg_r)
                        quot <= $signed(q_nx);
                    else if (rem_nx != '0)
                        quot <= -$signed(q_nx) - NW'(1);
                    else
                        quot <= -$signed(q_nx);
                end
            end
        end
    end

    assert_go_idle_R4: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/tsa_stamp_capture.sv
module tsa_stamp_capture
    import tsa_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2000,
    parameter int CNT_W       = 32,
    parameter int BLK_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TS_W-1:0]  ts_now,
    input  logic             mst_flip,
    input  logic             slv_flip,
    input  logic [BLK_W-1:0] settle_blocks,
    output logic             started,
    output logic [TS_W-1:0]  m_ts,
    output logic             m_valid,
    output logic [31:0]      s_lo,
    output logic [CNT_W-1:0] pump_cnt,
    output logic             mute,
    output logic [1:0]       err_code
);
    localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);

    logic [BLK_W-1:0]  blocks;
    logic [WAIT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
        end else begin
            started <= start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !started) begin
            m_ts     <= '0;
            m_valid  <= 1'b0;
            s_lo     <= '0;
            pump_cnt <= '0;
            blocks   <= '0;
            wait_cnt <= '0;
            err_code <= ERR_NONE;
        end else begin
            if (mst_flip) begin
                m_ts    <= ts_now;
                m_valid <= 1'b1;
            end
            if (slv_flip) begin
                s_lo     <= ts_now[31:0];
                pump_cnt <= pump_cnt + 1'b1;
                if (blocks < settle_blocks) blocks <= blocks + 1'b1;
            end
            if (!m_valid && !mst_flip && err_code == ERR_NONE) begin
                if (wait_cnt == WAIT_W'(TIMEOUT_CYC - 1))
                    err_code <= ERR_NO_MASTER;
                else
                    wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    assign mute = !started || (blocks < settle_blocks);

    assert_pump_step_R7: assert property (@(posedge clk) disable iff (rst)
        (started && start && slv_flip) |=> pump_cnt == CNT_W'($past(pump_cnt) + 1'b1));
    assert_err_needs_silence_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_code[0]) |-> !m_valid);
endmodule

// File: rtl/tsa_align_top.sv
module tsa_align_top
    import tsa_pkg::*;
#(
    parameter int AUD_W       = 24,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       ts_now,
    input  logic              mst_flip,
    input  logic              slv_flip,
    input  logic [15:0]       safe_delay_us,
    input  logic [15:0]       sample_ticks,
    input  logic [7:0]        settle_blocks,
    input  logic [AUD_W-1:0]  audio_in,
    output logic [AUD_W-1:0]  audio_out,
    output logic              upd_done,
    output logic              stat_started,
    output logic [31:0]       stat_ts_lo,
    output logic [31:0]       stat_skew_us,
    output logic [15:0]       stat_rw_off,
    output logic [15:0]       stat_latency,
    output logic [31:0]       pump_cnt,
    output logic [1:0]        err_code
);
    ctl_state_t st;
    status_t    stat;

    logic              started, m_valid, mute;
    logic [TS_W-1:0]   m_ts;
    logic [31:0]       s_lo;

    logic signed [DIFF_W-1:0] diff;
    logic signed [NUM_W-1:0]  skew_num_c, off_num_c, skew_num_r, div_num, div_q;
    logic [DEN_W-1:0]         div_den;
    logic                     div_go, div_busy, div_done, trig;

    tsa_stamp_capture #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(32), .BLK_W(8)) u_cap (
        .clk(clk), .rst(rst), .start(start), .ts_now(ts_now),
        .mst_flip(mst_flip), .slv_flip(slv_flip), .settle_blocks(settle_blocks),
        .started(started), .m_ts(m_ts), .m_valid(m_valid), .s_lo(s_lo),
        .pump_cnt(pump_cnt), .mute(mute), .err_code(err_code)
    );

    always_comb begin
        diff       = clamp_diff($signed(m_ts - ts_now));
        skew_num_c = mul5(NUM_W'(diff));
        off_num_c  = skew_num_c + us_to_x5ticks(safe_delay_us);
        trig       = started && start && slv_flip && m_valid && (st == ST_IDLE) && !div_busy;
        div_go     = trig || (st == ST_OFFSET && div_done);
        div_num    = (st == ST_IDLE) ? off_num_c : skew_num_r;
        div_den    = (st == ST_IDLE) ? (DEN_W'(sample_ticks) << 2) + DEN_W'(sample_ticks)
                                     : DEN_W'(96);
    end

    tsa_floor_div #(.NW(NUM_W), .DW(DEN_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quot(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst || !started) begin
            st         <= ST_IDLE;
            stat       <= '0;
            skew_num_r <= '0;
            upd_done   <= 1'b0;
        end else begin
            upd_done <= 1'b0;
            unique case (st)
                ST_IDLE: if (trig) begin
                    skew_num_r <= skew_num_c;
                    st         <= ST_OFFSET;
                end
                ST_OFFSET: if (div_done) begin
                    stat.rw_off  <= clamp_off(div_q);
                    stat.latency <= clamp_off(div_q);
                    st           <= ST_SKEW;
                end
                ST_SKEW: if (div_done) begin
                    stat.skew_us <= clamp_skew(div_q);
                    upd_done     <= 1'b1;
                    st           <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign stat_started = started;
    assign stat_ts_lo   = s_lo;
    assign stat_skew_us = stat.skew_us;
    assign stat_rw_off  = stat.rw_off;
    assign stat_latency = stat.latency;
    assign audio_out    = mute ? '0 : audio_in;

    assert_mute_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        !stat_started |-> audio_out == '0);
    assert_upd_when_started_R4: assert property (@(posedge clk) disable iff (rst)
        upd_done |-> stat_started);
    assert_no_master_no_work_R10: assert property (@(posedge clk) disable iff (rst)
        (!m_valid && st == ST_IDLE) |=> st == ST_IDLE);
endmodule

// File: tb/tb_tsa_align_top.sv
module tb_tsa_align_top;
    localparam int AW = 24;
    localparam int TMO = 2000;

    logic clk = 1'b0;
    logic rst, start, mst_flip, slv_flip, upd_done, stat_started;
    logic [63:0] ts_now;
    logic [15:0] safe_delay_us, sample_ticks, stat_rw_off, stat_latency;
    logic [7:0]  settle_blocks;
    logic [AW-1:0] audio_in, audio_out;
    logic [31:0] stat_ts_lo, stat_skew_us, pump_cnt;
    logic [1:0]  err_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    longint exp_pump = 0;

    always #5 clk = ~clk;

    tsa_align_top #(.AUD_W(AW), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .start(start), .ts_now(ts_now),
        .mst_flip(mst_flip), .slv_flip(slv_flip), .safe_delay_us(safe_delay_us),
        .sample_ticks(sample_ticks), .settle_blocks(settle_blocks),
        .audio_in(audio_in), .audio_out(audio_out), .upd_done(upd_done),
        .stat_started(stat_started), .stat_ts_lo(stat_ts_lo),
        .stat_skew_us(stat_skew_us), .stat_rw_off(stat_rw_off),
        .stat_latency(stat_latency), .pump_cnt(pump_cnt), .err_code(err_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint fdiv(input longint n, input longint d);
        longint q;
        q = n / d;
        if ((n % d) != 0 && n < 0) q = q - 1;
        return q;
    endfunction

    task automatic pulse_m(input logic [63:0] t);
        @(negedge clk);
        ts_now = t;
        mst_flip = 1'b1;
        @(negedge clk);
        mst_flip = 1'b0;
    endtask

    task automatic pulse_s(input logic [63:0] t);
        @(negedge clk);
        ts_now = t;
        slv_flip = 1'b1;
        if (start && stat_started) exp_pump++;
        @(negedge clk);
        slv_flip = 1'b0;
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        repeat (200) begin
            @(negedge clk);
            if (upd_done) n++;
        end
    endtask

    task automatic run_pair(input longint diff, input int dly, input int ticks, input string tag);
        logic [63:0] m, s;
        int n;
        longint en, es;
        m = 64'hA5C3_0000_0000_0000 + 64'($urandom);
        s = m - 64'(diff);
        safe_delay_us = 16'(dly);
        sample_ticks = 16'(ticks);
        pulse_m(m);
        pulse_s(s);
        wait_upd(n);
        en = fdiv(5 * diff + 96 * longint'(dly), 5 * longint'(ticks));
        es = fdiv(5 * diff, 96);
        chk({tag, " R4 single update pulse"}, n, 1);
        chk({tag, " R4 offset"}, longint'($signed(stat_rw_off)), en);
        chk({tag, " R5 skew_us"}, longint'($signed(stat_skew_us)), es);
        chk({tag, " R6 latency"}, longint'($signed(stat_latency)), en);
        chk({tag, " R3 ts_lo"}, longint'(stat_ts_lo), longint'(s[31:0]));
        chk({tag, " R7 pump"}, longint'(pump_cnt), exp_pump);
    endtask

    initial begin
        int n;
        void'($urandom(32'd1357));
        rst = 1'b1; start = 1'b0; mst_flip = 1'b0; slv_flip = 1'b0;
        ts_now = '0; safe_delay_us = '0; sample_ticks = 16'd400;
        settle_blocks = 8'd3; audio_in = 24'h123456;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 started", stat_started, 0);
        chk("R1 pump", pump_cnt, 0);
        chk("R1 err", err_code, 0);
        chk("R1 offset", stat_rw_off, 0);
        chk("R1 audio", audio_out, 0);
        chk("R1 upd", upd_done, 0);

        pulse_m(64'd7);
        pulse_s(64'd5);
        wait_upd(n);
        chk("R7 no update while stopped", n, 0);
        chk("R7 pump while stopped", pump_cnt, 0);
        chk("R2 ts_lo held while stopped", stat_ts_lo, 0);

        start = 1'b1;
        @(negedge clk);
        chk("R2 started follows", stat_started, 1);
        chk("R8 muted after start", audio_out, 0);

        pulse_s(64'd100);
        wait_upd(n);
        chk("R10 no update before master", n, 0);
        chk("R10 pump counted", pump_cnt, exp_pump);
        chk("R3 ts_lo slave only", stat_ts_lo, 100);

        run_pair(0, 0, 400, "zero");
        chk("R8 still muted at 2 blocks", audio_out, 0);
        run_pair(-1, 0, 400, "minus1");
        chk("R8 passes after 3 blocks", audio_out, 24'h123456);
        audio_in = 24'hABCDEF;
        #1;
        chk("R8 follows audio_in", audio_out, 24'hABCDEF);
        run_pair(-400, 0, 400, "minus_period");
        run_pair(-401, 0, 400, "minus_period_1");
        run_pair(399, 0, 400, "below_period");
        run_pair(400, 0, 400, "exact_period");
        run_pair(0, 25, 400, "delay25");
        run_pair(-96, 0, 100, "skew_exact");

        for (int i = 0; i < 20; i++) begin
            longint d;
            int dl, tk;
            d  = longint'($urandom_range(2000000, 0)) - 1000000;
            dl = int'($urandom_range(500, 0));
            case ($urandom_range(3, 0))
                0: tk = 400;
                1: tk = 200;
                2: tk = 441;
                default: tk = 100;
            endcase
            run_pair(d, dl, tk, "random");
        end

        start = 1'b0;
        exp_pump = 0;
        repeat (2) @(negedge clk);
        chk("R2 pump cleared on stop", pump_cnt, 0);
        chk("R2 offset cleared on stop", stat_rw_off, 0);
        chk("R2 started low", stat_started, 0);

        start = 1'b1;
        repeat (100) @(negedge clk);
        chk("R9 no error early", err_code, 0);
        repeat (TMO + 20) @(negedge clk);
        chk("R9 timeout error", err_code, 1);
        pulse_m(64'd9999);
        chk("R9 error sticky", err_code, 1);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 error cleared by stop", err_code, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule